// File: doc/BRIEF.md
# Soft-Start and Fault Supervisor

This block sequences start-up and fault recovery for a double-ended PWM controller. It watches three digitised samples (supply voltage, reference voltage and die temperature) and a level input that inhibits the outputs. From them it runs a digital soft-start ramp. The controller's error value is passed on clamped to the lower of itself and the ramp, so duty cycle grows from zero at start-up. The block also raises an output-enable flag that tells the steering stage whether it may drive the power switches.

Supply and temperature are judged with hysteresis. A low reference also counts as a fault. An overcurrent is handled elsewhere and never reaches this block as a fault. When a fault appears, the ramp is pulled down by a large fixed amount every cycle and the outputs are held off. A new soft-start only begins once the fault is gone and the ramp has dropped below a small reset level. In normal rise the ramp gains one LSB every N clock cycles, where N is an input, and it stops at a ceiling.

Codes: supply and reference in 10 mV per LSB, temperature in 1 °C per LSB, ramp and error value in 5 mV per LSB. So the ramp ceiling is 900, the reset level 54, the inhibit level 50 and the zero-duty level 120.

Top module: `ss_supervisor`

## Requirements
- R1: While rst_n is low, state_o is 0 (idle), ramp_code and ctrl_code are 0, out_en is 0 and duty_zero is 1. State encoding on state_o: 0 idle, 1 discharge, 2 ramp, 3 run, 4 fault.
- R2: The supply is good once vdd_code reaches 875 and stays good until vdd_code falls below 700. A bad supply forces state 4 within two cycles. A supply between 700 and 874 neither starts nor stops operation.
- R3: Temperature becomes a fault at temp_code 140 or above and clears only at 125 or below. A value in between keeps the previous verdict.
- R4: vref_code below 450 is a fault and forces state 4.
- R5: In state 4, ramp_code falls by 64 each cycle, or to 0 when it is 64 or less. ctrl_code is 0 and out_en is 0.
- R6: Leaving fault or inhibit goes through state 1. State 2 is entered from state 1 only when the ramp value in the cycle before is below 54 and inhibit is low.
- R7: In states 2 and 3, ramp_code rises by exactly one every max(step_div,1) clock cycles.
- R8: ramp_code never exceeds 900 and holds at 900 once reached.
- R9: In states 2 and 3, ctrl_code equals the lesser of err_code and ramp_code. In every other state it is 0.
- R10: State 2 moves to state 3 when ramp_code exceeds err_code or reaches 900.
- R11: inhibit high in state 2 or 3 moves the block to state 1 on the next edge, with out_en low. While inhibit stays high, the block remains in state 1 and the ramp discharges.
- R12: out_en is 1 exactly when the state is 2 or 3 and ramp_code is at least 50.
- R13: duty_zero is 1 exactly when ctrl_code is below 120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdd_code | input | 12 | Supply sample, 10 mV/LSB |
| vref_code | input | 10 | Reference sample, 10 mV/LSB |
| temp_code | input | 8 | Die temperature, 1 °C/LSB |
| inhibit | input | 1 | External disable level |
| err_code | input | 10 | Error amplifier value, 5 mV/LSB |
| step_div | input | 8 | Clock cycles per ramp LSB |
| ramp_code | output | 10 | Soft-start ramp value |
| ctrl_code | output | 10 | Clamped control value |
| out_en | output | 1 | Output enable for the steering stage |
| duty_zero | output | 1 | Control value below the zero-duty level |
| state_o | output | 3 | Sequencer state |

## Verification
A wrong hysteresis flag shows up as a state change, or a missing one, at state_o two edges after the threshold crossing. A lost fault shows as out_en staying high where it must drop. A ramp divider that is off by one makes ramp_code drift from the expected slope, and the error becomes visible after a few tens of cycles. A restart gate that is too early shows state 2 entered while the ramp still sits above 54. A wrong clamp shows in ctrl_code in the same cycle.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DISCH = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_FAULT = 3'd4
  } ss_state_e;

  // outputs may switch only in these states
  function automatic logic drives_on(ss_state_e s);
    return (s == ST_RAMP) || (s == ST_RUN);
  endfunction
endpackage

// File: rtl/ss_hyst.sv
module ss_hyst #(
  parameter int W = 12,
  parameter logic [W-1:0] SET_AT = '1,
  parameter logic [W-1:0] CLR_BELOW = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  output logic         flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (sample >= SET_AT)  flag <= 1'b1;
    else if (sample < CLR_BELOW) flag <= 1'b0;
  end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int RW = 10,
  parameter int DW = 8,
  parameter logic [RW-1:0] CEIL = 900,
  parameter logic [RW-1:0] DIS_STEP = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          charge,
  input  logic [DW-1:0] step_div,
  output logic [RW-1:0] ramp,
  output logic          step_due
);
  logic [DW-1:0] div_cnt;

  function automatic logic tick_now(logic [DW-1:0] cnt, logic [DW-1:0] n);
    if (n <= DW'(1)) return 1'b1;
    return cnt >= n - DW'(1);
  endfunction

  function automatic logic [RW-1:0] fall(logic [RW-1:0] v);
    return (v > DIS_STEP) ? v - DIS_STEP : '0;
  endfunction

  assign step_due = charge && tick_now(div_cnt, step_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      ramp    <= '0;
    end else if (!charge) begin
      div_cnt <= '0;
      ramp    <= fall(ramp);
    end else if (step_due) begin
      div_cnt <= '0;
      if (ramp < CEIL) ramp <= ramp + RW'(1);
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end
endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
  import ss_pkg::*;
#(
  parameter int RW = 10,
  parameter logic [RW-1:0] RST_THR = 54,
  parameter logic [RW-1:0] CEIL = 900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic          inhibit,
  input  logic [RW-1:0] ramp,
  input  logic [RW-1:0] err,
  output ss_state_e     state,
  output logic          ramp_done
);
  ss_state_e nxt;

  assign ramp_done = (ramp > err) || (ramp >= CEIL);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  nxt = fault ? ST_FAULT : ST_DISCH;
      ST_DISCH: if (fault) nxt = ST_FAULT;
                else if (!inhibit && ramp < RST_THR) nxt = ST_RAMP;
      ST_RAMP:  if (fault) nxt = ST_FAULT;
                else if (inhibit) nxt = ST_DISCH;
                else if (ramp_done) nxt = ST_RUN;
      ST_RUN:   if (fault) nxt = ST_FAULT;
                else if (inhibit) nxt = ST_DISCH;
      ST_FAULT: if (!fault) nxt = ST_DISCH;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ss_supervisor.sv
module ss_supervisor
  import ss_pkg::*;
#(
  parameter int VW = 12,
  parameter int FW = 10,
  parameter int TW = 8,
  parameter int RW = 10,
  parameter int DW = 8,
  parameter int UV_START = 875,
  parameter int UV_STOP = 700,
  parameter int REF_MIN = 450,
  parameter int HOT_SET = 140,
  parameter int HOT_CLEAR = 125,
  parameter int SS_CEIL = 900,
  parameter int SS_RST = 54,
  parameter int SS_INH = 50,
  parameter int ZERO_DUTY = 120,
  parameter int DIS_STEP = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vdd_code,
  input  logic [FW-1:0] vref_code,
  input  logic [TW-1:0] temp_code,
  input  logic          inhibit,
  input  logic [RW-1:0] err_code,
  input  logic [DW-1:0] step_div,
  output logic [RW-1:0] ramp_code,
  output logic [RW-1:0] ctrl_code,
  output logic          out_en,
  output logic          duty_zero,
  output logic [2:0]    state_o
);
  localparam logic [FW-1:0] REF_MIN_L = FW'(REF_MIN);
  localparam logic [RW-1:0] CEIL_L    = RW'(SS_CEIL);
  localparam logic [RW-1:0] RST_L     = RW'(SS_RST);
  localparam logic [RW-1:0] INH_L     = RW'(SS_INH);
  localparam logic [RW-1:0] ZD_L      = RW'(ZERO_DUTY);

  // named internal events, observed by the bound checker
  logic      supply_ok_w, hot_w, ref_ok_w, fault_w, active_w, step_due_w, ramp_done_w;
  ss_state_e state;

  function automatic logic [RW-1:0] lesser(logic [RW-1:0] a, logic [RW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  ss_hyst #(.W(VW), .SET_AT(VW'(UV_START)), .CLR_BELOW(VW'(UV_STOP))) u_uvlo (
    .clk(clk), .rst_n(rst_n), .sample(vdd_code), .flag(supply_ok_w));

  ss_hyst #(.W(TW), .SET_AT(TW'(HOT_SET)), .CLR_BELOW(TW'(HOT_CLEAR + 1))) u_therm (
    .clk(clk), .rst_n(rst_n), .sample(temp_code), .flag(hot_w));

  assign ref_ok_w = vref_code >= REF_MIN_L;
  assign fault_w  = !supply_ok_w || !ref_ok_w || hot_w;

  ss_fsm #(.RW(RW), .RST_THR(RST_L), .CEIL(CEIL_L)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fault(fault_w), .inhibit(inhibit),
    .ramp(ramp_code), .err(err_code), .state(state), .ramp_done(ramp_done_w));

  assign active_w = drives_on(state);

  ss_ramp #(.RW(RW), .DW(DW), .CEIL(CEIL_L), .DIS_STEP(RW'(DIS_STEP))) u_ramp (
    .clk(clk), .rst_n(rst_n), .charge(active_w), .step_div(step_div),
    .ramp(ramp_code), .step_due(step_due_w));

  assign ctrl_code = active_w ? lesser(err_code, ramp_code) : '0;
  assign out_en    = active_w && (ramp_code >= INH_L);
  assign duty_zero = ctrl_code < ZD_L;
  assign state_o   = state;
endmodule

// File: rtl/ss_supervisor_chk.sv
module ss_supervisor_chk
  import ss_pkg::*;
#(
  parameter int RW = 10,
  parameter int SS_CEIL = 900,
  parameter int SS_RST = 54,
  parameter int SS_INH = 50,
  parameter int DIS_STEP = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    state_o,
  input logic [RW-1:0] ramp_code,
  input logic [RW-1:0] ctrl_code,
  input logic [RW-1:0] err_code,
  input logic          out_en,
  input logic          fault_w
);
  localparam logic [RW:0] CEIL_X = (RW+1)'(SS_CEIL);
  localparam logic [RW:0] RST_X  = (RW+1)'(SS_RST);
  localparam logic [RW:0] INH_X  = (RW+1)'(SS_INH);
  localparam logic [RW:0] DIS_X  = (RW+1)'(DIS_STEP);

  logic [RW:0] ramp_x;
  logic        act;
  assign ramp_x = {1'b0, ramp_code};
  assign act    = (state_o == 3'(ST_RAMP)) || (state_o == 3'(ST_RUN));

  assert_fault_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_w && act) |=> (state_o == 3'(ST_FAULT)));

  assert_fault_discharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'(ST_FAULT) && ramp_x >= DIS_X) |=> (ramp_x == $past(ramp_x) - DIS_X));

  assert_restart_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'(ST_RAMP) && $past(state_o) == 3'(ST_DISCH)) |-> ({1'b0, $past(ramp_code)} < RST_X));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (ramp_x <= {1'b0, $past(ramp_code)} + (RW+1)'(1)));

  assert_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_x <= CEIL_X);

  assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (ctrl_code <= err_code && ctrl_code <= ramp_code &&
             (ctrl_code == err_code || ctrl_code == ramp_code)));

  assert_idle_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (ctrl_code == '0));

  assert_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> (act && ramp_x >= INH_X));
endmodule

bind ss_supervisor ss_supervisor_chk #(
  .RW(RW), .SS_CEIL(SS_CEIL), .SS_RST(SS_RST), .SS_INH(SS_INH), .DIS_STEP(DIS_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .ramp_code(ramp_code),
  .ctrl_code(ctrl_code), .err_code(err_code), .out_en(out_en), .fault_w(fault_w)
);

// File: tb/tb_ss_supervisor.sv
module tb_ss_supervisor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] vdd_code = 12'd0;
  logic [9:0]  vref_code = 10'd500;
  logic [7:0]  temp_code = 8'd25;
  logic        inhibit = 1'b0;
  logic [9:0]  err_code = 10'd1000;
  logic [7:0]  step_div = 8'd2;
  logic [9:0]  ramp_code, ctrl_code;
  logic        out_en, duty_zero;
  logic [2:0]  state_o;

  int vectors = 0;
  int misses = 0;

  ss_supervisor dut (
    .clk(clk), .rst_n(rst_n), .vdd_code(vdd_code), .vref_code(vref_code),
    .temp_code(temp_code), .inhibit(inhibit), .err_code(err_code),
    .step_div(step_div), .ramp_code(ramp_code), .ctrl_code(ctrl_code),
    .out_en(out_en), .duty_zero(duty_zero), .state_o(state_o));

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lesser(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic t_reset();
    cyc(3);
    chk("R1 state", state_o, 0);
    chk("R1 ramp", ramp_code, 0);
    chk("R1 ctrl", ctrl_code, 0);
    chk("R1 out_en", out_en, 0);
    chk("R1 duty_zero", duty_zero, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_uvlo_start();
    vdd_code = 12'd800;
    cyc(10);
    chk("R2 no start at 800", state_o, 4);
    vdd_code = 12'd875;
    cyc(2);
    chk("R2 leave fault via discharge R6", state_o, 1);
    cyc(1);
    chk("R6 ramp entered from zero", state_o, 2);
  endtask

  task automatic t_ramp_window();
    // step_div 2, err 1000: walk the ramp through inhibit and zero-duty levels
    for (int i = 0; i < 130; i++) begin
      cyc(1);
      chk("R12 out_en", out_en, (ramp_code >= 50) ? 1 : 0);
      chk("R9 ctrl tracks ramp", ctrl_code, lesser(int'(err_code), int'(ramp_code)));
      chk("R13 duty_zero", duty_zero, (ctrl_code < 120) ? 1 : 0);
    end
    chk("R7 still ramping", state_o, 2);
  endtask

  task automatic t_rate(int n);
    int r0;
    step_div = 8'(n);
    cyc(12);
    r0 = ramp_code;
    cyc(10 * n);
    chk($sformatf("R7 slope N=%0d", n), ramp_code - r0, 10);
  endtask

  task automatic t_ceiling();
    step_div = 8'd1;
    cyc(1000);
    chk("R8 ceiling", ramp_code, 900);
    chk("R10 run at ceiling", state_o, 3);
    chk("R9 ctrl at ceiling", ctrl_code, 900);
    cyc(20);
    chk("R8 holds", ramp_code, 900);
  endtask

  task automatic t_clamp();
    err_code = 10'd300;
    cyc(1);
    chk("R9 clamp to err", ctrl_code, 300);
    chk("R13 above zero level", duty_zero, 0);
    err_code = 10'd100;
    cyc(1);
    chk("R9 clamp low err", ctrl_code, 100);
    chk("R13 below zero level", duty_zero, 1);
    err_code = 10'd1000;
  endtask

  task automatic t_inhibit();
    int r0;
    inhibit = 1'b1;
    cyc(1);
    chk("R11 discharge state", state_o, 1);
    chk("R11 out_en low", out_en, 0);
    cyc(30);
    chk("R11 held while inhibit", state_o, 1);
    chk("R11 ramp drained", ramp_code, 0);
    inhibit = 1'b0;
    cyc(1);
    chk("R6 restart after inhibit", state_o, 2);
    // ramp up to a known point, then check the run transition on a low error value
    err_code = 10'd30;
    step_div = 8'd1;
    cyc(29);
    r0 = ramp_code;
    chk("R10 not yet run", state_o, 2);
    cyc(4);
    chk("R10 run when ramp passes err", state_o, 3);
    chk("R9 ctrl limited by err", ctrl_code, 30);
    if (r0 > 30) chk("R10 ramp reached early", r0, 30);
    err_code = 10'd1000;
  endtask

  task automatic t_thermal_midramp();
    inhibit = 1'b1;
    cyc(30);
    inhibit = 1'b0;
    step_div = 8'd2;
    cyc(100);
    chk("R3 midramp before fault", state_o, 2);
    temp_code = 8'd140;
    cyc(2);
    chk("R3 hot fault", state_o, 4);
    chk("R5 out_en low in fault", out_en, 0);
    chk("R5 ctrl zero in fault", ctrl_code, 0);
    temp_code = 8'd130;
    cyc(20);
    chk("R3 hysteresis holds fault", state_o, 4);
    temp_code = 8'd125;
    cyc(2);
    chk("R3 clear to discharge", state_o, 1);
    cyc(1);
    chk("R6 restart from drained ramp", state_o, 2);
    temp_code = 8'd25;
  endtask

  task automatic t_uvlo_stop_and_gate();
    int prev_state, prev_ramp, waited;
    step_div = 8'd1;
    cyc(1000);
    vdd_code = 12'd750;
    cyc(10);
    chk("R2 stays up at 750", state_o, 3);
    vdd_code = 12'd699;
    cyc(2);
    chk("R2 stop below 700", state_o, 4);
    chk("R5 ramp before first step", ramp_code, 900);
    cyc(1);
    chk("R5 discharge step", ramp_code, 836);
    cyc(1);
    chk("R5 discharge step 2", ramp_code, 772);
    vdd_code = 12'd900;
    prev_state = state_o;
    prev_ramp = ramp_code;
    waited = 0;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (state_o == 1 && prev_ramp >= 54) waited++;
      if (prev_state == 1 && state_o == 2) begin
        chk("R6 restart gate ramp below 54", (prev_ramp < 54) ? 1 : 0, 1);
        break;
      end
      if (prev_state == 1 && prev_ramp < 54)
        chk("R6 late restart", state_o, 2);
      prev_state = state_o;
      prev_ramp = ramp_code;
    end
    chk("R6 waited in discharge", (waited > 0) ? 1 : 0, 1);
    chk("R6 running again", state_o, 2);
  endtask

  task automatic t_reference();
    vref_code = 10'd449;
    cyc(2);
    chk("R4 reference fault", state_o, 4);
    vref_code = 10'd450;
    cyc(1);
    chk("R4 reference recovered", state_o, 1);
  endtask

  initial begin
    t_reset();
    t_uvlo_start();
    t_ramp_window();
    t_rate(5);
    t_rate(3);
    t_ceiling();
    t_clamp();
    t_inhibit();
    t_thermal_midramp();
    t_uvlo_stop_and_gate();
    t_reference();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule